// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a MAC-side byte stream into memory buffers chosen by a ring of descriptors that software maintains. Each descriptor takes three consecutive 32-bit words. The first word is a status word. The second word holds the buffer capacity in its upper half and, after a frame, the stored length in its lower half. The third word holds the buffer address. Software hands a descriptor to the engine by setting its ownership bit. The engine fills the buffer, writes the length and status back, and clears the ownership bit to return the descriptor.

The engine fetches each descriptor before the frame that will use it arrives. Incoming bytes are packed into little-endian words and written one word per access. When a frame ends, the length word and then the status word are written back. The engine then moves to the next descriptor, or wraps to the ring base when the end-of-list bit is set. If the descriptor it fetches is not owned, the engine stops itself and drops traffic until software sets the run request again.

Top module: `rxring_dma`

## Requirements
- R1: After reset, `rx_run` is 0, no memory access is made, and the descriptor pointer is at the ring base.
- R2: A one-cycle pulse on `rx_go` while stopped sets `rx_run` on the next edge. The engine then reads the current descriptor's three words, in order, at `ring_base` + offset + 0, 4 and 8.
- R3: Bytes of an accepted frame are stored in arrival order as little-endian 32-bit words: byte k goes to bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4. The buffer address comes from word 2 with its low 5 bits forced to zero. A final partial word has its unused upper bytes written as zero.
- R4: When a frame completes, word 1 is written as {capacity (bits 31:16, unchanged), stored byte count (bits 15:0)}.
- R5: Word 0 is written after word 1, with ownership bit 31 cleared, end-of-list bit 30 kept as fetched, error bit 27 set or cleared for this frame, and all other bits zero.
- R6: If `s_err` is high on any byte of an accepted frame, bit 27 of word 0 is set, and the data and length are still written.
- R7: Bytes beyond the capacity in word 1 are not written to memory. In that case bit 27 is set and the stored length equals the capacity.
- R8: After a descriptor with bit 30 set, the next descriptor is fetched at `ring_base`. Otherwise it is fetched at the current descriptor address + 12.
- R9: If the fetched word 0 has bit 31 clear, `rx_run` clears and the engine makes no memory access until the next `rx_go`. Frames that arrive in the meantime are dropped.
- R10: A frame whose first byte arrives while the engine is not waiting with an owned descriptor is dropped entirely, up to and including its last byte, even if the engine becomes ready in the middle of that frame.
- R11: A pulse on `rx_go` while running has no effect. A restart after a self-stop fetches again the same descriptor that was found not owned.
- R12: Every memory access uses a word-aligned address (bits 1:0 zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of the first descriptor in the ring |
| rx_go | input | 1 | Pulse that sets the run request |
| rx_run | output | 1 | Run request state; cleared by the engine when it runs out of owned descriptors |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_err | input | 1 | Error indication from the MAC for this frame |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |

## Verification
Frame lengths are swept from 1 to 14 bytes against a 12-byte capacity. This exercises every final-word fill (one to four bytes with zero padding), the exact-fit case, and two overflow lengths that must clamp and flag. Running the sweep around a three-descriptor ring with misaligned buffer addresses shows wrap-around, the end-of-list bit kept in the write-back, and the forced alignment. Bytes spaced out with idle cycles check that packing does not depend on back-to-back arrival. Further tests check the drop cases: a frame sent too soon after the previous one, a frame sent while self-stopped after an unowned fetch, and a frame whose head arrives before a restart. In each case untouched buffers and status words show that the dropped bytes were ignored, and the next frame then lands in the expected descriptor.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W      = 32;
  localparam int HALF_W      = WORD_W / 2;
  localparam int BYTE_W      = 8;
  localparam int OWN_BIT     = 31;
  localparam int LIST_END_BIT = 30;
  localparam int FAULT_BIT   = 27;
  localparam int DESC_STRIDE = 12;
  localparam int ALIGN_BITS  = 5;

  typedef enum logic [3:0] {
    ST_STOP,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_ARMED,
    ST_RX,
    ST_FLUSH,
    ST_WB1,
    ST_WB0
  } ring_state_t;
endpackage

// File: rtl/rxd_framer.sv
module rxd_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_last,
  input  logic armed,
  output logic take,
  output logic start,
  output logic done
);
  logic busy_q, busy_d;
  logic drop_q, drop_d;
  logic first;

  always_comb begin
    first  = s_valid && !busy_q && !drop_q;
    start  = first && armed;
    take   = s_valid && (busy_q || start);
    done   = take && s_last;
    busy_d = busy_q;
    if (done)
      busy_d = 1'b0;
    else if (take)
      busy_d = 1'b1;
    drop_d = (first && !armed && !s_last) || (drop_q && !(s_valid && s_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               start,
  input  logic [BYTE_W-1:0]  s_data,
  input  logic               s_last,
  input  logic               s_err,
  input  logic [HALF_W-1:0]  buf_size,
  input  logic [ADDR_W-1:0]  buf_addr,
  output logic               wr_go,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic [HALF_W-1:0]  frm_len,
  output logic               frm_err
);
  localparam int LANE_W = $clog2(WORD_W / BYTE_W);

  logic [HALF_W-1:0] cnt_q, cnt_d, cnt_base, cnt_inc;
  logic [WORD_W-1:0] acc_q, acc_d, acc_fill;
  logic              err_q, err_d, err_base;
  logic              go_d;
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] data_d;
  logic [LANE_W-1:0] lane;
  logic              room, flush;

  always_comb begin
    cnt_base = start ? '0 : cnt_q;
    err_base = start ? 1'b0 : err_q;
    cnt_inc  = cnt_base + 1'b1;
    lane     = cnt_base[LANE_W-1:0];
    room     = cnt_base < buf_size;
    flush    = (lane == LANE_W'((WORD_W / BYTE_W) - 1)) || s_last || (cnt_inc == buf_size);
    acc_fill = ((lane == '0) ? '0 : acc_q) |
               ({{(WORD_W-BYTE_W){1'b0}}, s_data} << {lane, 3'b000});
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    err_d  = err_q;
    go_d   = 1'b0;
    addr_d = wr_addr;
    data_d = wr_data;
    if (take) begin
      err_d = err_base || s_err;
      if (room) begin
        cnt_d  = cnt_inc;
        acc_d  = acc_fill;
        go_d   = flush;
        data_d = acc_fill;
        addr_d = buf_addr + {{(ADDR_W-HALF_W){1'b0}}, cnt_base[HALF_W-1:LANE_W], {LANE_W{1'b0}}};
      end else begin
        cnt_d = cnt_base;
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
      wr_go   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_go <= go_d;
      if (take) begin
        cnt_q   <= cnt_d;
        acc_q   <= acc_d;
        err_q   <= err_d;
        wr_addr <= addr_d;
        wr_data <= data_d;
      end
    end
  end

  assign frm_len = cnt_q;
  assign frm_err = err_q;
endmodule

// File: rtl/rxd_ring_ctrl.sv
module rxd_ring_ctrl
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic               rx_go,
  input  logic [WORD_W-1:0]  rd_data,
  input  logic               frm_take,
  input  logic               frm_done,
  input  logic               pk_go,
  input  logic [ADDR_W-1:0]  pk_addr,
  input  logic [WORD_W-1:0]  pk_data,
  input  logic [HALF_W-1:0]  frm_len,
  input  logic               frm_err,
  output logic               armed,
  output logic               rx_run,
  output logic [HALF_W-1:0]  buf_size,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - 1'b1);

  ring_state_t       st_q, st_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              eol_q, eol_d;
  logic [HALF_W-1:0] size_q, size_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [ADDR_W-1:0] desc_addr;
  logic              c_en, c_we;
  logic [ADDR_W-1:0] c_addr;
  logic [WORD_W-1:0] c_data, wb0;

  always_comb begin
    desc_addr = ring_base + {{(ADDR_W-OFF_W){1'b0}}, off_q};
    wb0 = '0;
    wb0[LIST_END_BIT] = eol_q;
    wb0[FAULT_BIT]    = frm_err;
    st_d    = st_q;
    off_d   = off_q;
    eol_d   = eol_q;
    size_d  = size_q;
    baddr_d = baddr_q;
    c_en    = 1'b0;
    c_we    = 1'b0;
    c_addr  = desc_addr;
    c_data  = '0;
    case (st_q)
      ST_STOP:  if (rx_go) st_d = ST_RD0;
      ST_RD0: begin
        c_en = 1'b1;
        st_d = ST_RD1;
      end
      ST_RD1: begin
        c_en   = 1'b1;
        c_addr = desc_addr + ADDR_W'(4);
        if (rd_data[OWN_BIT]) begin
          eol_d = rd_data[LIST_END_BIT];
          st_d  = ST_RD2;
        end else begin
          st_d = ST_STOP;
        end
      end
      ST_RD2: begin
        c_en   = 1'b1;
        c_addr = desc_addr + ADDR_W'(8);
        size_d = rd_data[WORD_W-1:HALF_W];
        st_d   = ST_RD3;
      end
      ST_RD3: begin
        baddr_d = rd_data & ALIGN_MASK;
        st_d    = ST_ARMED;
      end
      ST_ARMED: begin
        if (frm_done)
          st_d = ST_FLUSH;
        else if (frm_take)
          st_d = ST_RX;
      end
      ST_RX:    if (frm_done) st_d = ST_FLUSH;
      ST_FLUSH: st_d = ST_WB1;
      ST_WB1: begin
        c_en   = 1'b1;
        c_we   = 1'b1;
        c_addr = desc_addr + ADDR_W'(4);
        c_data = {size_q, frm_len};
        st_d   = ST_WB0;
      end
      ST_WB0: begin
        c_en   = 1'b1;
        c_we   = 1'b1;
        c_data = wb0;
        off_d  = eol_q ? '0 : off_q + OFF_W'(DESC_STRIDE);
        st_d   = ST_RD0;
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_STOP;
      off_q   <= '0;
      eol_q   <= 1'b0;
      size_q  <= '0;
      baddr_q <= '0;
    end else begin
      st_q    <= st_d;
      off_q   <= off_d;
      eol_q   <= eol_d;
      size_q  <= size_d;
      baddr_q <= baddr_d;
    end
  end

  always_comb begin
    if (pk_go) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = pk_addr;
      mem_wdata = pk_data;
    end else begin
      mem_en    = c_en;
      mem_we    = c_we;
      mem_addr  = c_addr;
      mem_wdata = c_data;
    end
  end

  assign armed    = (st_q == ST_ARMED);
  assign rx_run   = (st_q != ST_STOP);
  assign buf_size = size_q;
  assign buf_addr = baddr_q;
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic               rx_go,
  output logic               rx_run,
  input  logic               s_valid,
  input  logic [BYTE_W-1:0]  s_data,
  input  logic               s_last,
  input  logic               s_err,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);
  logic              armed, take, start, done;
  logic              pk_go, frm_err;
  logic [ADDR_W-1:0] pk_addr, buf_addr;
  logic [WORD_W-1:0] pk_data;
  logic [HALF_W-1:0] frm_len, buf_size;

  rxd_framer u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_last  (s_last),
    .armed   (armed),
    .take    (take),
    .start   (start),
    .done    (done)
  );

  rxd_packer #(.ADDR_W(ADDR_W)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .start    (start),
    .s_data   (s_data),
    .s_last   (s_last),
    .s_err    (s_err),
    .buf_size (buf_size),
    .buf_addr (buf_addr),
    .wr_go    (pk_go),
    .wr_addr  (pk_addr),
    .wr_data  (pk_data),
    .frm_len  (frm_len),
    .frm_err  (frm_err)
  );

  rxd_ring_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .rx_go     (rx_go),
    .rd_data   (mem_rdata),
    .frm_take  (take),
    .frm_done  (done),
    .pk_go     (pk_go),
    .pk_addr   (pk_addr),
    .pk_data   (pk_data),
    .frm_len   (frm_len),
    .frm_err   (frm_err),
    .armed     (armed),
    .rx_run    (rx_run),
    .buf_size  (buf_size),
    .buf_addr  (buf_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_go,
  input logic              rx_run,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R12: all accesses on word boundaries
  a_r12_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[1:0] == 2'b00));

  // R9: a stopped engine leaves memory alone
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |-> !mem_en);

  // R2: a start request while stopped takes effect on the next edge
  a_r2_start_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_run && rx_go) |=> rx_run);

  // R2: running only begins after a start request
  a_r2_rise_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_run) |-> $past(rx_go));

  // R9: a self-stop always follows a descriptor read
  a_r9_stop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_run) |-> $past(mem_en && !mem_we));
endmodule

bind rxring_dma rxring_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_go    (rx_go),
  .rx_run   (rx_run),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/rxring_dma_test.sv
module rxring_dma_test;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] EOL  = 32'h4000_0000;
  localparam logic [31:0] ERRB = 32'h0800_0000;
  localparam int CAP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = BASE;
  logic        rx_go = 1'b0;
  logic        rx_run;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_last = 1'b0;
  logic        s_err = 1'b0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic [31:0] mem [0:1023];
  int checks = 0;
  int errors = 0;
  int misaligned = 0;
  int idle_access = 0;
  int nxt = 0;

  always #10 clk = ~clk;

  rxring_dma uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_go(rx_go), .rx_run(rx_run),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_addr[1:0] != 2'b00) misaligned++;
      if (!rx_run) idle_access++;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  function automatic logic [31:0] daddr(int d);
    return BASE + 32'(12 * d);
  endfunction

  function automatic logic [31:0] baddr(int d);
    return 32'h400 + 32'(d * 'h40);
  endfunction

  function automatic logic [7:0] fbyte(int n, int i);
    return 8'((n * 16 + i + 1) & 255);
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(int d, bit own);
    mem[daddr(d) >> 2]       = (own ? OWN : 32'h0) | ((d == 2) ? EOL : 32'h0);
    mem[(daddr(d) >> 2) + 1] = {16'(CAP), 16'hBEEF};
    mem[(daddr(d) >> 2) + 2] = baddr(d) | 32'(d * 7 + 3);
    for (int w = 0; w < 16; w++) mem[(baddr(d) >> 2) + w] = 32'hFFFF_FFFF;
  endtask

  task automatic send_part(int n, int from, int upto, bit with_last, bit err, bit gaps);
    for (int i = from; i < upto; i++) begin
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        s_valid = 1'b0;
      end
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = fbyte(n, i);
      s_last  = with_last && (i == upto - 1);
      s_err   = err && (i == upto - 1);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_err   = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk);
    rx_go = 1'b1;
    @(negedge clk);
    rx_go = 1'b0;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic check_frame(int d, int n, int len, bit err);
    int stored;
    logic [31:0] w;
    stored = (len > CAP) ? CAP : len;
    for (int k = 0; k < (stored + 3) / 4; k++) begin
      w = 32'h0;
      for (int b = 0; b < 4; b++)
        if (k * 4 + b < stored) w |= 32'(fbyte(n, k * 4 + b)) << (8 * b);
      chk("R3 packed word", rd(baddr(d) + 32'(4 * k)), w);
    end
    chk("R7 word past data untouched", rd(baddr(d) + 32'(4 * ((stored + 3) / 4))), 32'hFFFF_FFFF);
    chk((len > CAP) ? "R7 clamped length" : "R4 length word", rd(daddr(d) + 4), {16'(CAP), 16'(stored)});
    chk(err ? "R6 error status" : ((len > CAP) ? "R7 overflow status" : "R5 status word"),
        rd(daddr(d)), ((d == 2) ? EOL : 32'h0) | ((err || len > CAP) ? ERRB : 32'h0));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int d = 0; d < 3; d++) arm(d, 1'b1);
    idle(3);
    chk("R1 run after reset", 32'(rx_run), 32'h0);
    chk("R1 no access in reset", 32'(mem_en), 32'h0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 stays stopped", 32'(rx_run), 32'h0);
    pulse_go();
    chk("R2 run after go", 32'(rx_run), 32'h1);
    idle(10);

    // length sweep, capacity 12, wraps ring of three (R8)
    for (int n = 0; n < 14; n++) begin
      if (n == 5) begin
        pulse_go();
        chk("R11 go while running", 32'(rx_run), 32'h1);
      end
      send_part(n, 0, n + 1, 1'b1, n == 4, n % 3 == 1);
      idle(20);
      if (nxt == 0 && n > 0) $display("R8 wrap frame %0d into first descriptor", n);
      check_frame(nxt, n, n + 1, n == 4);
      arm(nxt, 1'b1);
      nxt = (nxt + 1) % 3;
    end

    // R10: frame arriving before engine re-armed is dropped
    send_part(20, 0, 5, 1'b1, 1'b0, 1'b0);
    idle(1);
    send_part(21, 0, 6, 1'b1, 1'b0, 1'b0);
    idle(20);
    check_frame(nxt, 20, 5, 1'b0);
    chk("R10 early frame not stored", rd(baddr((nxt + 1) % 3)), 32'hFFFF_FFFF);
    chk("R10 next status untouched", rd(daddr((nxt + 1) % 3)), OWN | (((nxt + 1) % 3 == 2) ? EOL : 32'h0));
    arm(nxt, 1'b1);
    nxt = (nxt + 1) % 3;
    send_part(22, 0, 9, 1'b1, 1'b0, 1'b0);
    idle(20);
    check_frame(nxt, 22, 9, 1'b0);
    arm(nxt, 1'b1);
    nxt = (nxt + 1) % 3;

    // R9: unowned descriptor stops the engine
    arm((nxt + 1) % 3, 1'b0);
    send_part(23, 0, 4, 1'b1, 1'b0, 1'b0);
    idle(20);
    check_frame(nxt, 23, 4, 1'b0);
    chk("R9 run cleared", 32'(rx_run), 32'h0);
    arm(nxt, 1'b1);
    nxt = (nxt + 1) % 3;
    send_part(24, 0, 6, 1'b1, 1'b0, 1'b0);
    idle(20);
    chk("R9 frame dropped while stopped", rd(baddr(nxt)), 32'hFFFF_FFFF);
    chk("R9 status unchanged while stopped", rd(daddr(nxt)), (nxt == 2) ? EOL : 32'h0);
    chk("R9 still stopped", 32'(rx_run), 32'h0);

    // R10: head before restart, tail after, whole frame dropped
    arm(nxt, 1'b1);
    send_part(25, 0, 3, 1'b0, 1'b0, 1'b0);
    pulse_go();
    chk("R2 restart", 32'(rx_run), 32'h1);
    idle(12);
    send_part(25, 3, 6, 1'b1, 1'b0, 1'b0);
    idle(20);
    chk("R10 tail dropped", rd(baddr(nxt)), 32'hFFFF_FFFF);
    chk("R10 status still owned", rd(daddr(nxt)), OWN | ((nxt == 2) ? EOL : 32'h0));

    // R11: resumes at the same descriptor
    send_part(26, 0, 7, 1'b1, 1'b0, 1'b1);
    idle(20);
    check_frame(nxt, 26, 7, 1'b0);
    chk("R11 running after resume", 32'(rx_run), 32'h1);

    chk("R12 aligned accesses", 32'(misaligned), 32'h0);
    chk("R9 no access while stopped", 32'(idle_access), 32'h0);
    finish_run();
  end
endmodule